// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Sequencer

This block is the bus interface state machine of a 16-bit processor with a 20-bit address space. It takes one transfer request at a time from the core (memory or I/O space, read or write, byte or word, with the segment source and the interrupt-enable flag) and runs it on a single set of shared pins. The low 16 lines carry address first and data later. The upper four lines carry address first and status later.

Each bus cycle walks through the clock states T1, T2, T3, any number of wait states, and T4. In T1 the block raises the address latch strobe, drives the address and drives the byte-high enable. From T2 onward the upper lines switch to status, and the data lines either float (read) or carry write data. The device ready input is sampled at the end of T3 and at the end of every wait state. A word at an odd address is broken into two byte cycles. When nothing is pending the bus sits in idle clocks. A new request can start in the clock after the last T4, so cycles can run back to back with no idle clock.

Top module: `mxbus_sequencer`

## Requirements
- R1: A request that is accepted at a clock edge runs T1, T2, T3, then T4 in the clocks that follow, so a cycle lasts at least four clocks. `rsp_done` is high for exactly one clock, in the clock right after the final T4.
- R2: In T1, `bus_ale` is 1 and `bus_ad_oe` is 1. `bus_ad_out` carries address bits 15:0. For memory cycles `bus_upper` carries address bits 19:16. `bus_ale` is 0 in every other state.
- R3: On a read, `bus_ad_oe` is 0 from T2 through T4 and `bus_rd_n` is 0 from T2 through T4. On a write, `bus_ad_oe` is 1 and `bus_ad_out` carries the write data from T2 through T4, and `bus_wr_n` is 0 in T2, T3 and any wait state. Both strobes are 1 in T1 and in T4, except that `bus_rd_n` stays 0 in T4 of a read.
- R4: `bus_ready` is sampled at the end of T3 and at the end of each wait state. When it is 0, exactly one more one-clock wait state follows. When it is 1, T4 follows.
- R5: From T2 through T4, `bus_upper` is {1'b0, ie, seg[1:0]}. The segment code is 00 extra, 01 stack, 10 code or none, 11 data.
- R6: For an I/O cycle, `bus_upper` is 0 in T1 and `bus_io_sel` is 1 from T1 through T4. `bus_io_sel` is 0 for memory cycles and in idle.
- R7: An even-address byte moves on bits 7:0 and an odd-address byte moves on bits 15:8. A byte write drives its byte on both halves. A byte read returns the selected half in `rsp_rdata[7:0]`, with bits 15:8 set to zero.
- R8: `bus_bhe_n` is 0 in T1 for an aligned word or an odd-address byte. It is 1 in T1 for an even-address byte, and it is 1 in every state other than T1.
- R9: A word at an odd address A runs as two byte cycles: A first, then A+1 (modulo 2^20). A read returns {byte at A+1, byte at A}. A write sends the low data byte first and the high data byte second. There is a single `rsp_done`, after the second cycle.
- R10: With no request pending, the bus idles: `bus_ale` 0, `bus_ad_oe` 0, `bus_upper` 0, `bus_bhe_n`, `bus_rd_n` and `bus_wr_n` 1, `bus_io_sel` 0, and `bus_ctype` 3'b111.
- R11: `bus_ctype` is the transfer code from T1 through the last wait state: 3'b001 I/O read, 3'b010 I/O write, 3'b101 memory read, 3'b110 memory write. It is 3'b111 (passive) in T4 and in idle.
- R12: `req_ready` is 1 in idle and in the final T4 of a transfer. A request accepted in that T4 starts T1 in the very next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core presents a transfer request |
| req_ready | output | 1 | Request is taken at this clock edge if valid |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = 16-bit transfer, 0 = byte |
| req_addr | input | 20 | Byte address |
| req_wdata | input | 16 | Write data (byte in bits 7:0) |
| req_seg | input | 2 | Segment source code |
| req_ie | input | 1 | Interrupt-enable flag for status |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Read data, valid with rsp_done on a read |
| bus_ad_out | output | 16 | Shared address/data lines, outgoing value |
| bus_ad_oe | output | 1 | Output enable for the shared lines |
| bus_ad_in | input | 16 | Shared lines, incoming value |
| bus_upper | output | 4 | Address 19:16 in T1, status afterwards |
| bus_ale | output | 1 | Address latch strobe |
| bus_bhe_n | output | 1 | Byte-high enable, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_io_sel | output | 1 | 1 during an I/O cycle |
| bus_ctype | output | 3 | Transfer type code |
| bus_ready | input | 1 | Addressed device is ready |

## Verification
A wrong state register shows at the pins in the same clock. The strobe, the output enable, the upper-line contents and the type code all follow from the state, so a state that skips or repeats is seen at the first sample after the bad edge. A wrong byte-lane or split decision shows in T1 as a wrong address or byte-high enable, or in T2 as wrong write lanes. A wrong piece counter shows as a missing or extra second cycle, or as a response that comes one cycle too early. Read-data assembly errors are visible only in the clock after the final T4, when the bench compares `rsp_rdata` against bytes it placed on the bus itself.

// File: rtl/mxbus_pkg.sv
// Package: shared clock-state type and transfer type codes for the bus sequencer.
// Assumes a single active transfer at a time.
package mxbus_pkg;

    typedef enum logic [2:0] {
        PH_TI = 3'd0,
        PH_T1 = 3'd1,
        PH_T2 = 3'd2,
        PH_T3 = 3'd3,
        PH_TW = 3'd4,
        PH_T4 = 3'd5
    } phase_e;

    localparam logic [2:0] CT_PASSIVE = 3'b111;

    // Transfer type code: memory read 101, memory write 110, I/O read 001, I/O write 010.
    function automatic logic [2:0] ctype_of(input logic io, input logic wr);
        return {~io, wr, ~wr};
    endfunction

endpackage

// File: rtl/mxbus_fsm.sv
// Module: clock-state machine of the bus cycle (TI, T1, T2, T3, TW, T4).
// Assumes 'start' is raised only in TI or T4; samples device ready in T3 and TW.
module mxbus_fsm
    import mxbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   start,
    input  logic   bus_ready,
    output phase_e phase
);

    phase_e nxt;

    // Next-state selection for the bus clock states.
    always_comb begin
        nxt = phase;
        unique case (phase)
            PH_TI:        nxt = start ? PH_T1 : PH_TI;
            PH_T1:        nxt = PH_T2;
            PH_T2:        nxt = PH_T3;
            PH_T3, PH_TW: nxt = bus_ready ? PH_T4 : PH_TW;
            PH_T4:        nxt = start ? PH_T1 : PH_TI;
            default:      nxt = PH_TI;
        endcase
    end

    // State register with synchronous reset to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_TI;
        else        phase <= nxt;
    end

    // R1: T1 is always followed by T2, and T2 by T3.
    p_t1_to_t2_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_T1 |=> phase == PH_T2);
    p_t2_to_t3_r1: assert property (@(posedge clk) disable iff (!rst_n)
        phase == PH_T2 |=> phase == PH_T3);
    // R4: not-ready in T3 or TW gives exactly one more wait state.
    p_wait_insert_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T3 || phase == PH_TW) && !bus_ready) |=> phase == PH_TW);
    p_wait_leave_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_T3 || phase == PH_TW) && bus_ready) |=> phase == PH_T4);
    // R12: a new cycle starts only from idle or T4.
    p_start_legal_r12: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (phase == PH_TI || phase == PH_T4));

endmodule

// File: rtl/mxbus_xfer.sv
// Module: request capture, odd-word splitting into two byte cycles, read-data
// assembly and completion pulse. Assumes the core holds a request until ready.
module mxbus_xfer
    import mxbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  phase_e            phase,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_io,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [1:0]        req_seg,
    input  logic              req_ie,
    input  logic [DW-1:0]     bus_din,
    output logic              start,
    output logic [AW-1:0]     cur_addr,
    output logic              cur_bus_word,
    output logic [DW/2-1:0]   cur_byte,
    output logic [DW-1:0]     cur_wdata,
    output logic              cur_io,
    output logic              cur_wr,
    output logic              cur_ie,
    output logic [1:0]        cur_seg,
    output logic              rsp_done,
    output logic [DW-1:0]     rsp_rdata
);

    localparam int BW = DW / 2;

    logic          split_q;
    logic          piece_q;
    logic          last;
    logic          accept;
    logic          next_piece;
    logic [BW-1:0] byte_in;

    // Handshake and piece sequencing decisions.
    always_comb begin
        last       = !split_q || piece_q;
        req_ready  = (phase == PH_TI) || (phase == PH_T4 && last);
        accept     = req_valid && req_ready;
        next_piece = (phase == PH_T4) && !last;
        start      = accept || next_piece;
        cur_byte   = (split_q && piece_q) ? cur_wdata[DW-1:BW] : cur_wdata[BW-1:0];
        byte_in    = cur_addr[0] ? bus_din[DW-1:BW] : bus_din[BW-1:0];
    end

    // Request latch and address advance for the second half of a split word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_addr     <= '0;
            cur_bus_word <= 1'b0;
            cur_wdata    <= '0;
            cur_io       <= 1'b0;
            cur_wr       <= 1'b0;
            cur_ie       <= 1'b0;
            cur_seg      <= 2'b00;
            split_q      <= 1'b0;
            piece_q      <= 1'b0;
        end else if (accept) begin
            cur_addr     <= req_addr;
            cur_bus_word <= req_word && !req_addr[0];
            cur_wdata    <= req_wdata;
            cur_io       <= req_io;
            cur_wr       <= req_write;
            cur_ie       <= req_ie;
            cur_seg      <= req_seg;
            split_q      <= req_word && req_addr[0];
            piece_q      <= 1'b0;
        end else if (next_piece) begin
            cur_addr     <= cur_addr + AW'(1);
            piece_q      <= 1'b1;
        end
    end

    // Completion pulse and read-data capture at the end of T4.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_done  <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= (phase == PH_T4) && last;
            if (phase == PH_T4 && !cur_wr) begin
                if (cur_bus_word)           rsp_rdata <= bus_din;
                else if (split_q && piece_q) rsp_rdata[DW-1:BW] <= byte_in;
                else                        rsp_rdata <= {{BW{1'b0}}, byte_in};
            end
        end
    end

    // R1: a completion pulse never lasts two clocks.
    p_done_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    // R1: completion follows a T4.
    p_done_after_t4_r1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |-> $past(phase) == PH_T4);
    // R9: the second piece of a split word addresses the next byte.
    p_split_next_addr_r9: assert property (@(posedge clk) disable iff (!rst_n)
        next_piece |=> (cur_addr == $past(cur_addr) + AW'(1)) && phase == PH_T1);

endmodule

// File: rtl/mxbus_drive.sv
// Module: pin driver. Decodes the clock state and the active transfer into
// strobes, address/status on the upper lines, data lanes and type code.
// Assumes AW - DW >= 3 so the status field fits on the upper lines.
module mxbus_drive
    import mxbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  phase_e            phase,
    input  logic [AW-1:0]     addr,
    input  logic              bus_word,
    input  logic [DW/2-1:0]   byte_val,
    input  logic [DW-1:0]     wdata,
    input  logic              io,
    input  logic              wr,
    input  logic              ie,
    input  logic [1:0]        seg,
    output logic [DW-1:0]     bus_ad_out,
    output logic              bus_ad_oe,
    output logic [AW-DW-1:0]  bus_upper,
    output logic              bus_ale,
    output logic              bus_bhe_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_io_sel,
    output logic [2:0]        bus_ctype
);

    localparam int UW = AW - DW;

    logic [UW-1:0] status_v;
    logic [DW-1:0] wr_lanes;

    // Status word for the upper lines and write-lane steering.
    always_comb begin
        status_v      = '0;
        status_v[2]   = ie;
        status_v[1:0] = seg;
        wr_lanes      = bus_word ? wdata : {byte_val, byte_val};
    end

    // Pin values per clock state.
    always_comb begin
        bus_ad_out = '0;
        bus_ad_oe  = 1'b0;
        bus_upper  = '0;
        bus_ale    = 1'b0;
        bus_bhe_n  = 1'b1;
        bus_rd_n   = 1'b1;
        bus_wr_n   = 1'b1;
        bus_io_sel = 1'b0;
        bus_ctype  = CT_PASSIVE;
        unique case (phase)
            PH_T1: begin
                bus_ale    = 1'b1;
                bus_ad_oe  = 1'b1;
                bus_ad_out = addr[DW-1:0];
                bus_upper  = io ? '0 : addr[AW-1:DW];
                bus_bhe_n  = !(bus_word || addr[0]);
                bus_io_sel = io;
                bus_ctype  = ctype_of(io, wr);
            end
            PH_T2, PH_T3, PH_TW: begin
                bus_ad_oe  = wr;
                bus_ad_out = wr ? wr_lanes : '0;
                bus_upper  = status_v;
                bus_rd_n   = wr;
                bus_wr_n   = !wr;
                bus_io_sel = io;
                bus_ctype  = ctype_of(io, wr);
            end
            PH_T4: begin
                bus_ad_oe  = wr;
                bus_ad_out = wr ? wr_lanes : '0;
                bus_upper  = status_v;
                bus_rd_n   = wr;
                bus_io_sel = io;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/mxbus_sequencer.sv
// Module: top of the multiplexed address/data bus sequencer. Joins the state
// machine, the transfer tracker and the pin driver. Assumes one request in flight.
module mxbus_sequencer
    import mxbus_pkg::*;
#(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_io,
    input  logic              req_write,
    input  logic              req_word,
    input  logic [AW-1:0]     req_addr,
    input  logic [DW-1:0]     req_wdata,
    input  logic [1:0]        req_seg,
    input  logic              req_ie,
    output logic              rsp_done,
    output logic [DW-1:0]     rsp_rdata,
    output logic [DW-1:0]     bus_ad_out,
    output logic              bus_ad_oe,
    input  logic [DW-1:0]     bus_ad_in,
    output logic [AW-DW-1:0]  bus_upper,
    output logic              bus_ale,
    output logic              bus_bhe_n,
    output logic              bus_rd_n,
    output logic              bus_wr_n,
    output logic              bus_io_sel,
    output logic [2:0]        bus_ctype,
    input  logic              bus_ready
);

    localparam int BW = DW / 2;

    phase_e          phase;
    logic            start;
    logic [AW-1:0]   cur_addr;
    logic            cur_bus_word;
    logic [BW-1:0]   cur_byte;
    logic [DW-1:0]   cur_wdata;
    logic            cur_io;
    logic            cur_wr;
    logic            cur_ie;
    logic [1:0]      cur_seg;

    mxbus_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .bus_ready (bus_ready),
        .phase     (phase)
    );

    mxbus_xfer #(.AW(AW), .DW(DW)) u_xfer (
        .clk          (clk),
        .rst_n        (rst_n),
        .phase        (phase),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_io       (req_io),
        .req_write    (req_write),
        .req_word     (req_word),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_seg      (req_seg),
        .req_ie       (req_ie),
        .bus_din      (bus_ad_in),
        .start        (start),
        .cur_addr     (cur_addr),
        .cur_bus_word (cur_bus_word),
        .cur_byte     (cur_byte),
        .cur_wdata    (cur_wdata),
        .cur_io       (cur_io),
        .cur_wr       (cur_wr),
        .cur_ie       (cur_ie),
        .cur_seg      (cur_seg),
        .rsp_done     (rsp_done),
        .rsp_rdata    (rsp_rdata)
    );

    mxbus_drive #(.AW(AW), .DW(DW)) u_drive (
        .phase      (phase),
        .addr       (cur_addr),
        .bus_word   (cur_bus_word),
        .byte_val   (cur_byte),
        .wdata      (cur_wdata),
        .io         (cur_io),
        .wr         (cur_wr),
        .ie         (cur_ie),
        .seg        (cur_seg),
        .bus_ad_out (bus_ad_out),
        .bus_ad_oe  (bus_ad_oe),
        .bus_upper  (bus_upper),
        .bus_ale    (bus_ale),
        .bus_bhe_n  (bus_bhe_n),
        .bus_rd_n   (bus_rd_n),
        .bus_wr_n   (bus_wr_n),
        .bus_io_sel (bus_io_sel),
        .bus_ctype  (bus_ctype)
    );

    // R2: the latch strobe appears only in the first clock of a cycle.
    p_ale_in_t1_r2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ale |=> !bus_ale && !bus_bhe_n == 1'b0);
    // R6: I/O cycles never put address on the upper lines.
    p_io_upper_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_ale && bus_io_sel) |-> bus_upper == '0);

endmodule

// File: tb/mxbus_sequencer_bench.sv
// Bench: directed corner cases plus seeded random transfers, each pin compared
// every clock against values computed from the requirements.
module mxbus_sequencer_bench;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 20;
    localparam int DW = 16;
    localparam int PH_IDLE = 0;
    localparam int PH_FIRST = 1;
    localparam int PH_MID = 2;
    localparam int PH_LAST = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_ready;
    logic            req_io = 1'b0;
    logic            req_write = 1'b0;
    logic            req_word = 1'b0;
    logic [AW-1:0]   req_addr = '0;
    logic [DW-1:0]   req_wdata = '0;
    logic [1:0]      req_seg = 2'b00;
    logic            req_ie = 1'b0;
    logic            rsp_done;
    logic [DW-1:0]   rsp_rdata;
    logic [DW-1:0]   bus_ad_out;
    logic            bus_ad_oe;
    logic [DW-1:0]   bus_ad_in = '0;
    logic [3:0]      bus_upper;
    logic            bus_ale;
    logic            bus_bhe_n;
    logic            bus_rd_n;
    logic            bus_wr_n;
    logic            bus_io_sel;
    logic [2:0]      bus_ctype;
    logic            bus_ready = 1'b0;

    int checks = 0;
    int errors = 0;

    // context of the byte cycle under way
    logic [19:0] cx_addr;
    logic        cx_bw;
    logic [7:0]  cx_bv;
    logic [15:0] cx_wd;
    logic        cx_io, cx_wr, cx_ie;
    logic [1:0]  cx_seg;

    // request to present during a final T4 (back-to-back case)
    logic        nx_io, nx_wr, nx_word, nx_ie;
    logic [19:0] nx_addr;
    logic [15:0] nx_wd;
    logic [1:0]  nx_seg;

    mxbus_sequencer u_mxbus_sequencer (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_io(req_io), .req_write(req_write), .req_word(req_word),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_seg(req_seg),
        .req_ie(req_ie), .rsp_done(rsp_done), .rsp_rdata(rsp_rdata),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_upper(bus_upper), .bus_ale(bus_ale), .bus_bhe_n(bus_bhe_n),
        .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n), .bus_io_sel(bus_io_sel),
        .bus_ctype(bus_ctype), .bus_ready(bus_ready)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        summary();
        $finish;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual=%h expected=%h", req, $time, got, exp);
        end
    endtask

    function automatic logic [28:0] observed();
        return {bus_ale, bus_ad_oe, (bus_ad_oe ? bus_ad_out : 16'h0), bus_upper,
                bus_bhe_n, bus_rd_n, bus_wr_n, bus_io_sel, bus_ctype};
    endfunction

    // Expected pin vector from the requirements (R2, R3, R5, R6, R8, R10, R11).
    function automatic logic [28:0] expected(input int ph);
        logic [15:0] wv;
        logic [2:0]  code;
        logic [3:0]  stat;
        wv   = cx_bw ? cx_wd : {cx_bv, cx_bv};
        code = {~cx_io, cx_wr, ~cx_wr};
        stat = {1'b0, cx_ie, cx_seg};
        case (ph)
            PH_FIRST: return {1'b1, 1'b1, cx_addr[15:0], (cx_io ? 4'h0 : cx_addr[19:16]),
                              !(cx_bw || cx_addr[0]), 1'b1, 1'b1, cx_io, code};
            PH_MID:   return {1'b0, cx_wr, (cx_wr ? wv : 16'h0), stat,
                              1'b1, cx_wr, !cx_wr, cx_io, code};
            PH_LAST:  return {1'b0, cx_wr, (cx_wr ? wv : 16'h0), stat,
                              1'b1, cx_wr, 1'b1, cx_io, 3'b111};
            default:  return {1'b0, 1'b0, 16'h0, 4'h0, 1'b1, 1'b1, 1'b1, 1'b0, 3'b111};
        endcase
    endfunction

    task automatic check_pins(input int ph, input string req);
        logic [28:0] g, e;
        g = observed();
        e = expected(ph);
        chk(g == e, req, 64'(g), 64'(e));
    endtask

    // One transfer. pre: already accepted, now at the negedge inside its T1.
    // chain: present nx_* during the final T4.
    task automatic do_txn(input logic io, input logic wr, input logic word,
                          input logic [19:0] addr, input logic [15:0] wd,
                          input logic [1:0] seg, input logic ie,
                          input int w0, input int w1, input bit pre, input bit chain);
        logic        split;
        int          npieces;
        logic [15:0] exp_rd;
        logic [15:0] din;
        logic [7:0]  bval;
        split   = word & addr[0];
        npieces = split ? 2 : 1;
        exp_rd  = 16'h0;
        if (!pre) begin
            req_io = io; req_write = wr; req_word = word; req_addr = addr;
            req_wdata = wd; req_seg = seg; req_ie = ie; req_valid = 1'b1;
            chk(req_ready == 1'b1, "R12 ready", 64'(req_ready), 64'(1));
            @(negedge clk);
        end
        req_valid = 1'b0;
        for (int p = 0; p < npieces; p++) begin
            cx_addr = (p == 0) ? addr : addr + 20'd1;
            cx_bw   = word & !split;
            cx_bv   = (split && p == 1) ? wd[15:8] : wd[7:0];
            cx_wd = wd; cx_io = io; cx_wr = wr; cx_ie = ie; cx_seg = seg;
            if (p > 0) @(negedge clk);
            check_pins(PH_FIRST, "R2 R6 R8 R9 T1");
            @(negedge clk);
            check_pins(PH_MID, "R3 R5 R7 T2");
            @(negedge clk);
            for (int k = 0; k <= ((p == 0) ? w0 : w1); k++) begin
                check_pins(PH_MID, "R4 T3/TW");
                bus_ready = (k == ((p == 0) ? w0 : w1));
                @(negedge clk);
            end
            bus_ready = 1'b0;
            din = 16'($urandom);
            bus_ad_in = din;
            check_pins(PH_LAST, "R11 R3 T4");
            chk(rsp_done == 1'b0, "R1 no early done", 64'(rsp_done), 64'(0));
            bval = cx_addr[0] ? din[15:8] : din[7:0];
            if (cx_bw) exp_rd = din;
            else if (split && p == 1) exp_rd[15:8] = bval;
            else exp_rd = {8'h00, bval};
            if (p == npieces - 1 && chain) begin
                req_io = nx_io; req_write = nx_wr; req_word = nx_word; req_addr = nx_addr;
                req_wdata = nx_wd; req_seg = nx_seg; req_ie = nx_ie; req_valid = 1'b1;
                chk(req_ready == 1'b1, "R12 ready in T4", 64'(req_ready), 64'(1));
            end else if (p < npieces - 1) begin
                chk(req_ready == 1'b0, "R9 busy between halves", 64'(req_ready), 64'(0));
            end
        end
        @(negedge clk);
        chk(rsp_done == 1'b1, "R1 done pulse", 64'(rsp_done), 64'(1));
        if (!wr) chk(rsp_rdata == exp_rd, "R7 R9 read data", 64'(rsp_rdata), 64'(exp_rd));
        if (!chain) check_pins(PH_IDLE, "R10 idle");
    endtask

    initial begin
        int dummy;
        dummy = $urandom(32'h5eed_1234);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        check_pins(PH_IDLE, "R10 reset");
        chk(rsp_done == 1'b0, "R1 reset done", 64'(rsp_done), 64'(0));
        chk(req_ready == 1'b1, "R12 reset ready", 64'(req_ready), 64'(1));
        // idle stays idle
        repeat (3) @(negedge clk);
        check_pins(PH_IDLE, "R10 idle hold");

        // R7: byte reads and writes on each lane
        do_txn(1'b0, 1'b0, 1'b0, 20'h3A4B6, 16'h0000, 2'b11, 1'b1, 0, 0, 1'b0, 1'b0);
        do_txn(1'b0, 1'b0, 1'b0, 20'h3A4B7, 16'h0000, 2'b01, 1'b0, 1, 0, 1'b0, 1'b0);
        do_txn(1'b0, 1'b1, 1'b0, 20'h00102, 16'h12C5, 2'b00, 1'b1, 0, 0, 1'b0, 1'b0);
        do_txn(1'b0, 1'b1, 1'b0, 20'h00103, 16'h127E, 2'b10, 1'b0, 0, 0, 1'b0, 1'b0);
        // aligned word write and read
        do_txn(1'b0, 1'b1, 1'b1, 20'hC0DE0, 16'hBEEF, 2'b11, 1'b1, 2, 0, 1'b0, 1'b0);
        do_txn(1'b0, 1'b0, 1'b1, 20'h54320, 16'h0000, 2'b10, 1'b0, 0, 0, 1'b0, 1'b0);
        // R9: split word read with waits in both halves, split write
        do_txn(1'b0, 1'b0, 1'b1, 20'h10001, 16'h0000, 2'b01, 1'b1, 2, 3, 1'b0, 1'b0);
        do_txn(1'b0, 1'b1, 1'b1, 20'h20FFF, 16'hA55A, 2'b00, 1'b0, 0, 1, 1'b0, 1'b0);
        // R9: split at the top of the address space wraps to zero
        do_txn(1'b0, 1'b0, 1'b1, 20'hFFFFF, 16'h0000, 2'b11, 1'b0, 0, 0, 1'b0, 1'b0);
        // R6: I/O cycles with high address bits set in the request
        do_txn(1'b1, 1'b0, 1'b1, 20'hF1234, 16'h0000, 2'b10, 1'b1, 0, 0, 1'b0, 1'b0);
        do_txn(1'b1, 1'b1, 1'b0, 20'h7FF81, 16'h0099, 2'b01, 1'b0, 1, 0, 1'b0, 1'b0);
        // R4: long not-ready stretch
        do_txn(1'b0, 1'b0, 1'b0, 20'h0ABC4, 16'h0000, 2'b00, 1'b0, 7, 0, 1'b0, 1'b0);
        // R12: back-to-back cycles with no idle clock
        nx_io = 1'b0; nx_wr = 1'b1; nx_word = 1'b1; nx_addr = 20'h66661;
        nx_wd = 16'h3C4D; nx_seg = 2'b10; nx_ie = 1'b1;
        do_txn(1'b0, 1'b0, 1'b1, 20'h44440, 16'h0000, 2'b01, 1'b0, 0, 0, 1'b0, 1'b1);
        do_txn(nx_io, nx_wr, nx_word, nx_addr, nx_wd, nx_seg, nx_ie, 1, 0, 1'b1, 1'b0);

        // seeded random transfers with random idle gaps
        for (int n = 0; n < 300; n++) begin
            do_txn(1'($urandom), 1'($urandom), 1'($urandom), 20'($urandom), 16'($urandom),
                   2'($urandom), 1'($urandom), int'($urandom_range(0, 3)),
                   int'($urandom_range(0, 3)), 1'b0, 1'b0);
            if ($urandom_range(0, 3) == 0) begin
                @(negedge clk);
                check_pins(PH_IDLE, "R10 random gap");
            end
        end

        summary();
        $finish;
    end

endmodule